// File: doc/BRIEF.md
# Double-Buffered Serial Character Transmitter

This block turns parallel characters into an asynchronous serial line. A character written while the block is ready goes into a single holding slot. A separate shift stage sends the held character as a frame: a low start bit, the data bits, an optional parity bit and one or two high stop bits. Every bit of the frame lasts exactly one interval between pulses of the `baud_tick` input, which a baud generator outside the block supplies. Because the slot sits in front of the shift stage, the next character can be written while the current one is still on the line, and frames then follow each other with no idle time between them.

Two status outputs report progress. `ready` says that the holding slot can take a character. `empty` says that nothing is held and nothing is being shifted. The character length, the bit order, the parity mode and the stop-bit count are read when a character moves from the slot into the shift stage.

Top module: `sertx_dbuf`

## Requirements
- R1: While `tx_en` is high and `ready` is high, a cycle with `wr_valid` high stores `wr_char` in the holding slot, and `ready` is low from the next cycle.
- R2: A cycle with `wr_valid` high while `ready` is low changes nothing. The held character stays the one written earlier, and the dropped character never appears on `txd`.
- R3: While `tx_en` is low, `ready` and `empty` are low and `txd` is 1 from the cycle after `tx_en` falls. Any held or shifting character is discarded, writes are ignored, and nothing is sent after `tx_en` returns high.
- R4: A held character starts on the first `baud_tick` at which the shift stage is idle. No bit is sent without a tick. The frame is one start bit (0), the data bits, the parity bit if enabled, then the stop bits (1). Each bit appears on `txd` the cycle after a tick and holds until the cycle after the next tick. The idle line is 1.
- R5: `cfg_len` sets the character length from 5 to 9 bits, taken from `wr_char[len-1:0]`. A value below 5 acts as 5, and a value above 9 acts as 9.
- R6: With `cfg_msb_first` at 0 the data go least significant bit first. With it at 1 they go most significant bit first.
- R7: `cfg_parity` encodes the parity mode: 0 even (the parity bit makes the count of ones among the data and parity bits even), 1 odd, 2 parity bit forced to 0, 3 parity bit forced to 1, and 4 to 7 no parity bit.
- R8: `cfg_two_stop` at 0 gives one stop bit, and at 1 gives two.
- R9: At the tick that ends the last stop bit, a held character moves into the shift stage. Its start bit follows the previous stop bit with no gap, and `ready` is high the cycle after that tick.
- R10: `empty` is high only when `tx_en` is high, the slot is empty and no frame is in progress. It rises the cycle after the tick that ends the last stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| cfg_len | input | 4 | Character length, 5 to 9 |
| cfg_msb_first | input | 1 | 1 sends the most significant data bit first |
| cfg_parity | input | 3 | Parity mode code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| wr_valid | input | 1 | Write strobe for the holding slot |
| wr_char | input | 9 | Character to write |
| txd | output | 1 | Serial line |
| ready | output | 1 | Holding slot empty |
| empty | output | 1 | Nothing held or shifting |

## Verification
The bench sweeps every length, bit order, parity code and stop count with two data values each. It records the line once per tick and compares it bit by bit with a frame it builds itself. A builder that indexed the most-significant-first order wrongly, put the parity bit after the wrong data bit, or computed the parity with the wrong sense would show up as a wrong bit in the recorded frame.

Three sequences go after the corner cases. In the first, a character is written during the previous frame, and a third write is made while the slot is full. A design that left a gap between the frames, or that let the third write replace the held character, would produce a line that differs from the two expected frames. The second sequence disables the block in the middle of a frame. A design that kept the shifter running, or that accepted a write while disabled, would leave the line low or send another frame. The third checks lengths outside the legal range, where a design without clamping would send the wrong number of data bits.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Parity mode codes seen on the cfg_parity input
  typedef enum logic [2:0] {
    PAR_EVEN = 3'd0,
    PAR_ODD  = 3'd1,
    PAR_ZERO = 3'd2,
    PAR_ONE  = 3'd3,
    PAR_NONE = 3'd4
  } par_mode_e;

  // Parity bit for a mode, given the XOR of the data bits
  function automatic logic parity_value(input logic [2:0] mode, input logic xor_data);
    logic v;
    case (mode)
      3'(PAR_EVEN): v = xor_data;
      3'(PAR_ODD):  v = ~xor_data;
      3'(PAR_ZERO): v = 1'b0;
      3'(PAR_ONE):  v = 1'b1;
      default:      v = 1'b1;
    endcase
    return v;
  endfunction

  function automatic logic parity_used(input logic [2:0] mode);
    return (mode <= 3'(PAR_ONE));
  endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);

  logic          full_q, full_d;
  logic [DW-1:0] data_q;
  logic          accept;

  assign accept = en & wr_valid & ~full_q;

  always_comb begin
    full_d = full_q;
    if (!en)
      full_d = 1'b0;
    else if (take)
      full_d = 1'b0;
    else if (accept)
      full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      full_q <= 1'b0;
    else
      full_q <= full_d;
  end

  // Data register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (accept)
      data_q <= wr_data;
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
#(
  parameter int MAX_LEN = 9,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = 4,
  parameter int FW      = 13,
  parameter int CW      = 4
) (
  input  logic [MAX_LEN-1:0] data,
  input  logic [LEN_W-1:0]   len_cfg,
  input  logic               msb_first,
  input  logic [2:0]         par_cfg,
  input  logic               two_stop,
  output logic [FW-1:0]      frame,
  output logic [CW-1:0]      nbits
);

  logic [LEN_W-1:0]   len_eff;
  logic [MAX_LEN-1:0] mask;
  logic [MAX_LEN-1:0] dbits;
  logic               par_en;
  logic               par_bit;

  // Clamp the length into the legal range
  always_comb begin
    if (len_cfg < LEN_W'(MIN_LEN))
      len_eff = LEN_W'(MIN_LEN);
    else if (len_cfg > LEN_W'(MAX_LEN))
      len_eff = LEN_W'(MAX_LEN);
    else
      len_eff = len_cfg;
  end

  // Per-position data select: position p is the p-th data bit on the line
  for (genvar p = 0; p < MAX_LEN; p++) begin : g_pos
    logic sel;
    assign mask[p] = (LEN_W'(p) < len_eff);
    always_comb begin
      sel = 1'b0;
      for (int j = 0; j < MAX_LEN; j++) begin
        if (msb_first) begin
          if (LEN_W'(j) == (len_eff - LEN_W'(p + 1)))
            sel = data[j];
        end else if (j == p) begin
          sel = data[j];
        end
      end
    end
    assign dbits[p] = mask[p] & sel;
  end

  assign par_en  = parity_used(par_cfg);
  assign par_bit = parity_value(par_cfg, ^(data & mask));

  // Frame vector, bit 0 leaves first; unused upper bits stay 1 (stop/idle)
  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int k = 0; k < MAX_LEN; k++)
      if (mask[k])
        frame[k+1] = dbits[k];
    if (par_en)
      for (int k = MIN_LEN; k <= MAX_LEN; k++)
        if (LEN_W'(k) == len_eff)
          frame[k+1] = par_bit;
    nbits = CW'(len_eff) + CW'(2) + CW'(par_en) + CW'(two_stop);
  end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int FW = 13,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          have_char,
  input  logic [FW-1:0] frame_in,
  input  logic [CW-1:0] nbits_in,
  output logic          take,
  output logic          busy,
  output logic          txd
);

  logic          busy_q, busy_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_bit;

  assign last_bit = (cnt_q == CW'(1));
  assign take     = en & tick & have_char & (~busy_q | last_bit);

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    if (!en) begin
      busy_d = 1'b0;
      sh_d   = '1;
      cnt_d  = '0;
    end else if (tick) begin
      if (take) begin
        busy_d = 1'b1;
        sh_d   = frame_in;
        cnt_d  = nbits_in;
      end else if (busy_q) begin
        if (last_bit) begin
          busy_d = 1'b0;
          sh_d   = '1;
          cnt_d  = '0;
        end else begin
          sh_d  = {1'b1, sh_q[FW-1:1]};
          cnt_d = cnt_q - CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign txd  = sh_q[0];

endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf #(
  parameter int MAX_LEN = 9,
  parameter int MIN_LEN = 5,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic               baud_tick,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               cfg_msb_first,
  input  logic [2:0]         cfg_parity,
  input  logic               cfg_two_stop,
  input  logic               wr_valid,
  input  logic [MAX_LEN-1:0] wr_char,
  output logic               txd,
  output logic               ready,
  output logic               empty
);

  localparam int FW = MAX_LEN + 4;
  localparam int CW = $clog2(FW + 1);

  logic               hold_full;
  logic [MAX_LEN-1:0] hold_data;
  logic               take;
  logic               busy;
  logic [FW-1:0]      frame;
  logic [CW-1:0]      nbits;

  sertx_hold #(.DW(MAX_LEN)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (tx_en),
    .wr_valid (wr_valid),
    .wr_data  (wr_char),
    .take     (take),
    .full     (hold_full),
    .data     (hold_data)
  );

  sertx_frame #(
    .MAX_LEN (MAX_LEN),
    .MIN_LEN (MIN_LEN),
    .LEN_W   (LEN_W),
    .FW      (FW),
    .CW      (CW)
  ) u_frame (
    .data      (hold_data),
    .len_cfg   (cfg_len),
    .msb_first (cfg_msb_first),
    .par_cfg   (cfg_parity),
    .two_stop  (cfg_two_stop),
    .frame     (frame),
    .nbits     (nbits)
  );

  sertx_shift #(.FW(FW), .CW(CW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (tx_en),
    .tick      (baud_tick),
    .have_char (hold_full),
    .frame_in  (frame),
    .nbits_in  (nbits),
    .take      (take),
    .busy      (busy),
    .txd       (txd)
  );

  assign ready = tx_en & ~hold_full;
  assign empty = tx_en & ~hold_full & ~busy;

endmodule

// File: rtl/sertx_dbuf_chk.sv
module sertx_dbuf_chk #(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          baud_tick,
  input logic          wr_valid,
  input logic          ready,
  input logic          empty,
  input logic          txd,
  input logic          take,
  input logic          busy,
  input logic [DW-1:0] hold_data
);

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && ready && wr_valid) |=> !ready);

  p_drop_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !ready && wr_valid) |=> $stable(hold_data));

  p_idle_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> txd);

  p_flags_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (!ready && !empty));

  p_start_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!txd && busy));

  p_tick_paced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && !$past(baud_tick)) |-> $stable(txd));

  p_no_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && take) |=> busy);

  p_empty_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (ready && txd && !busy));

endmodule

bind sertx_dbuf sertx_dbuf_chk #(.DW(MAX_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_en     (tx_en),
  .baud_tick (baud_tick),
  .wr_valid  (wr_valid),
  .ready     (ready),
  .empty     (empty),
  .txd       (txd),
  .take      (take),
  .busy      (busy),
  .hold_data (hold_data)
);

// File: tb/sertx_dbuf_test.sv
module sertx_dbuf_test;

  localparam int B = 4;

  logic       clk = 1'b0;
  logic       rst_n, tx_en, baud_tick, cfg_msb, cfg_two_stop, wr_valid;
  logic [3:0] cfg_len;
  logic [2:0] cfg_par;
  logic [8:0] wr_char;
  logic       txd, ready, empty;

  int n_chk = 0;
  int n_fail = 0;

  logic lg_bit [0:127];
  logic lg_rdy [0:127];
  logic lg_emp [0:127];
  int   nlog;
  logic ex [0:127];
  int   nex;

  always #5 clk = ~clk;

  sertx_dbuf uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_en         (tx_en),
    .baud_tick     (baud_tick),
    .cfg_len       (cfg_len),
    .cfg_msb_first (cfg_msb),
    .cfg_parity    (cfg_par),
    .cfg_two_stop  (cfg_two_stop),
    .wr_valid      (wr_valid),
    .wr_char       (wr_char),
    .txd           (txd),
    .ready         (ready),
    .empty         (empty)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Tasks start and end just after a falling edge
  task automatic do_tick();
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
    lg_bit[nlog] = txd;
    lg_rdy[nlog] = ready;
    lg_emp[nlog] = empty;
    nlog++;
    repeat (B - 1) @(negedge clk);
  endtask

  task automatic write_char(input logic [8:0] d);
    wr_valid = 1'b1;
    wr_char  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic add_bit(input logic b);
    ex[nex] = b;
    nex++;
  endtask

  // Expected frame from the requirements, using the current configuration
  task automatic append_frame(input logic [8:0] d);
    int L;
    int ones;
    L = (cfg_len < 5) ? 5 : ((cfg_len > 9) ? 9 : int'(cfg_len));
    ones = 0;
    add_bit(1'b0);
    for (int i = 0; i < L; i++)
      add_bit(cfg_msb ? d[L-1-i] : d[i]);
    for (int i = 0; i < L; i++)
      ones += int'(d[i]);
    case (cfg_par)
      3'd0: add_bit(logic'(ones % 2));
      3'd1: add_bit(logic'(1 - ones % 2));
      3'd2: add_bit(1'b0);
      3'd3: add_bit(1'b1);
      default: ;
    endcase
    add_bit(1'b1);
    if (cfg_two_stop) add_bit(1'b1);
  endtask

  task automatic compare_log(input string req);
    int bad;
    bad = -1;
    for (int k = 0; k < nex; k++)
      if (lg_bit[k] !== ex[k] && bad < 0) bad = k;
    if (lg_bit[nex] !== 1'b1 && bad < 0) bad = nex;
    check(bad < 0, req, "line bit mismatch at index", bad, -1);
  endtask

  // One character from write to idle, with frame and flag checks
  task automatic run_one(input logic [8:0] d, input string req);
    int bad;
    nlog = 0;
    nex  = 0;
    append_frame(d);
    write_char(d);
    check(ready == 1'b0 && empty == 1'b0, "R1", "ready/empty after write",
          int'({ready, empty}), 0);
    repeat (nex + 1) do_tick();
    compare_log(req);
    check(lg_rdy[0] == 1'b1, "R9", "ready after load tick", int'(lg_rdy[0]), 1);
    bad = -1;
    for (int k = 0; k <= nex; k++)
      if (lg_emp[k] !== (k == nex) && bad < 0) bad = k;
    check(bad < 0, "R10", "empty wrong at tick index", bad, -1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [8:0] d;
    logic       all_one;
    rst_n = 1'b0; tx_en = 1'b0; baud_tick = 1'b0; wr_valid = 1'b0; wr_char = '0;
    cfg_len = 4'd8; cfg_msb = 1'b0; cfg_par = 3'd4; cfg_two_stop = 1'b0;
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && ready == 1'b0 && empty == 1'b0, "R3", "reset state",
          int'({txd, ready, empty}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b0 && empty == 1'b0, "R3", "flags while disabled",
          int'({ready, empty}), 0);
    tx_en = 1'b1;
    @(negedge clk);
    check(ready == 1'b1 && empty == 1'b1, "R10", "flags when enabled idle",
          int'({ready, empty}), 3);

    // R4: nothing leaves without a tick
    cfg_len = 4'd8; cfg_par = 3'd0;
    write_char(9'h0A5);
    all_one = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (txd !== 1'b1) all_one = 1'b0;
    end
    check(all_one, "R4", "line moved without tick", int'(all_one), 1);
    nlog = 0; nex = 0;
    append_frame(9'h0A5);
    repeat (nex + 1) do_tick();
    compare_log("R4");

    // Sweep over every frame format
    for (int len = 5; len <= 9; len++)
      for (int msb = 0; msb < 2; msb++)
        for (int par = 0; par < 6; par++)
          for (int st = 0; st < 2; st++)
            for (int dv = 0; dv < 2; dv++) begin
              cfg_len = 4'(len); cfg_msb = logic'(msb);
              cfg_par = 3'(par); cfg_two_stop = logic'(st);
              d = 9'((len * 37 + par * 11 + msb * 5 + st * 3 + dv * 101) ^ (dv * 9'h155));
              run_one(d, "R4,R5,R6,R7,R8 frame");
            end

    // R5: out-of-range lengths clamp
    cfg_msb = 1'b0; cfg_par = 3'd1; cfg_two_stop = 1'b0;
    cfg_len = 4'd3;
    run_one(9'h1F3, "R5 short clamp");
    cfg_len = 4'd14;
    run_one(9'h1A6, "R5 long clamp");

    // R9 and R2: back-to-back frames, third write dropped
    cfg_len = 4'd8; cfg_par = 3'd0; cfg_two_stop = 1'b1; cfg_msb = 1'b0;
    nlog = 0; nex = 0;
    append_frame(9'h03C);
    append_frame(9'h0C1);
    write_char(9'h03C);
    do_tick();
    check(ready == 1'b1, "R9", "ready after first load", int'(ready), 1);
    write_char(9'h0C1);
    check(ready == 1'b0, "R1", "ready after second write", int'(ready), 0);
    write_char(9'h0FF);
    check(ready == 1'b0, "R2", "ready after dropped write", int'(ready), 0);
    repeat (nex) do_tick();
    compare_log("R9 back-to-back");
    check(empty == 1'b1, "R10", "empty after both frames", int'(empty), 1);
    nlog = 0;
    repeat (3) do_tick();
    check(lg_bit[0] && lg_bit[1] && lg_bit[2], "R2", "dropped char sent",
          int'({lg_bit[0], lg_bit[1], lg_bit[2]}), 7);

    // R3: disable mid-frame, writes while disabled ignored
    nlog = 0;
    write_char(9'h000);
    do_tick();
    do_tick();
    check(lg_bit[1] == 1'b0, "R3", "data bit before disable", int'(lg_bit[1]), 0);
    tx_en = 1'b0;
    @(negedge clk);
    check(txd == 1'b1 && ready == 1'b0 && empty == 1'b0, "R3", "state after disable",
          int'({txd, ready, empty}), 4);
    write_char(9'h000);
    do_tick();
    check(txd == 1'b1, "R3", "line while disabled", int'(txd), 1);
    tx_en = 1'b1;
    @(negedge clk);
    check(ready == 1'b1 && empty == 1'b1, "R3", "flags after re-enable",
          int'({ready, empty}), 3);
    nlog = 0;
    repeat (4) do_tick();
    check(lg_bit[0] && lg_bit[1] && lg_bit[2] && lg_bit[3], "R3", "line after re-enable",
          int'({lg_bit[0], lg_bit[1], lg_bit[2], lg_bit[3]}), 15);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule